// File: doc/BRIEF.md
# Whole-Method Instruction Cache with Variable Block Allocation

This block is an instruction store for a bytecode processor. It keeps complete methods, not lines. Because of that, timing inside a method never depends on cache state. Residency is decided only when the processor calls a method or returns into one. If the method is resident, the switch costs no memory traffic. If it is not, the whole method is copied in from backing memory. After that, every bytecode fetch inside the method hits.

The storage is cut into small equal blocks, 16 blocks of 64 bytes by default. A method takes as many consecutive blocks as its length needs. Blocks are handed out circularly from a next-free pointer, and a copy that runs past the last block wraps to block 0. A tag table, with fewer slots than there are blocks, records each resident method's base address, first block and block count.

Two things evict a method:
- Its blocks overlap a new allocation.
- The table is full and it is the least recently used method.

A build parameter selects a simpler variant that treats every call or return as a miss and always loads the method at block 0.

The request port and the bytecode read port are valid/ready. A transfer happens on a clock edge where both valid and ready are high. Both ready signals are low for as long as a method copy is in progress. A requester must hold valid, base and length steady until ready returns. The memory port is a plain read strobe with an acknowledge.

Top module: `method_cache`

## Requirements
- R1: While reset is applied and after it is released, `busy` is 0, `req_ready` and `bc_ready` are 1, `mem_rd` is 0 and `bc_rvalid` is 0.
- R2: Accepting a request for a method that is not resident raises `busy` in the next cycle. The block then reads ceil(len/4) 32-bit words, starting at `req_base` and rising by 4 bytes per word. Each address is held on `mem_addr` with `mem_rd` high until `mem_ack`. `busy` falls in the cycle after the last acknowledge.
- R3: Accepting a request whose base address matches a resident method causes no memory read and leaves `busy` low. The matched method becomes current from the next cycle.
- R4: A bytecode read accepted on a clock edge gives `bc_rvalid`=1 in the next cycle. `bc_rdata` is the byte at `bc_offset` counted from the first byte of the current method. Within each fetched word, the byte at the lowest address is bits 7:0.
- R5: While `busy` is high, `req_ready` and `bc_ready` are both 0.
- R6: A method of len bytes takes ceil(len/64) consecutive blocks. They start at the next-free pointer, which then moves past them modulo 16. A method that runs past the last block continues at block 0, and reads across that boundary return correct bytes.
- R7: A resident method whose blocks overlap a new allocation stops being resident, and a later request for it is a miss. Methods that do not overlap the new allocation stay resident.
- R8: When all 4 tag slots hold methods and no method overlaps the new one, a miss replaces the least recently used method. Both a hit and a fill count as a use.
- R9: With `SINGLE_MODE`=1, every accepted request is a miss, including a repeated request for the same method, and the bytes read back are correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Call/return request is valid |
| req_ready | output | 1 | Request can be accepted |
| req_base | input | ADDR_W | Byte address of the method in backing memory (word aligned) |
| req_len | input | OFS_W+1 | Method length in bytes, 1 to MAX_BYTES |
| busy | output | 1 | A method copy is in progress |
| mem_rd | output | 1 | Word read request to backing memory |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_ack | input | 1 | Read completes; `mem_rdata` is valid |
| mem_rdata | input | 32 | Word returned by backing memory |
| bc_valid | input | 1 | Bytecode read request |
| bc_ready | output | 1 | Bytecode read can be accepted |
| bc_offset | input | OFS_W | Byte offset within the current method |
| bc_rvalid | output | 1 | Bytecode read data is valid |
| bc_rdata | output | 8 | Bytecode byte |

## Verification
The cache is given a mix of method lengths:
- one word and one byte, which check the ceil rounding of word counts;
- a full block, and lengths spanning several blocks;
- one length that wraps past the last block;
- one length that fills the whole array.

The sequence of calls is chosen so that hits, capacity evictions and overlap evictions each occur in turn. Counting memory acknowledges separates a hit from a miss. Bytes read back at chosen offsets, including both sides of the wrap point, show that words were placed in the right blocks and in the right order. A repeated call on the single-method variant shows that it never keeps a method resident.

// File: rtl/mcache_pkg.sv
package mcache_pkg;

  typedef enum logic {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fill_state_e;

  // Byte lane select, lowest address in bits 7:0.
  function automatic logic [7:0] lane_byte(input logic [31:0] w, input logic [1:0] sel);
    logic [7:0] b;
    case (sel)
      2'd0:    b = w[7:0];
      2'd1:    b = w[15:8];
      2'd2:    b = w[23:16];
      default: b = w[31:24];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/mcache_tags.sv
module mcache_tags #(
  parameter int ADDR_W      = 32,
  parameter int NUM_BLK     = 16,
  parameter int BLK_BYTES   = 64,
  parameter int NUM_TAGS    = 4,
  parameter int LEN_W       = 11,
  parameter bit SINGLE_MODE = 1'b0,
  localparam int BLK_W      = $clog2(NUM_BLK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_fire,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [LEN_W-1:0]  req_len,
  output logic              hit,
  output logic [BLK_W-1:0]  alloc_start,
  output logic [BLK_W-1:0]  cur_start
);
  localparam int IDX_W  = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1;
  localparam int BLK_SH = $clog2(BLK_BYTES);

  logic [NUM_TAGS-1:0] vld_q;
  logic [ADDR_W-1:0]   base_q  [NUM_TAGS];
  logic [BLK_W-1:0]    start_q [NUM_TAGS];
  logic [BLK_W:0]      cnt_q   [NUM_TAGS];
  logic [IDX_W-1:0]    age_q   [NUM_TAGS];
  logic [BLK_W-1:0]    free_q;
  logic [BLK_W-1:0]    cur_q;

  // Blocks needed by the incoming method
  logic [LEN_W:0] len_rnd;
  logic [BLK_W:0] need_blk;
  assign len_rnd  = {1'b0, req_len} + (LEN_W+1)'(BLK_BYTES - 1);
  assign need_blk = (BLK_W+1)'(len_rnd >> BLK_SH);

  // Base address lookup
  logic             hit_any;
  logic [IDX_W-1:0] hit_idx;
  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int i = 0; i < NUM_TAGS; i++) begin
      if (!hit_any && vld_q[i] && (base_q[i] == req_base)) begin
        hit_any = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
  assign hit = hit_any && !SINGLE_MODE;

  assign alloc_start = SINGLE_MODE ? '0 : free_q;

  // Circular overlap of each resident method with the new allocation
  logic [NUM_TAGS-1:0] ovl;
  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_ovl
    logic [BLK_W-1:0] fwd;
    logic [BLK_W-1:0] back;
    assign fwd    = start_q[g] - alloc_start;
    assign back   = alloc_start - start_q[g];
    assign ovl[g] = vld_q[g] && (({1'b0, fwd} < need_blk) || ({1'b0, back} < cnt_q[g]));
  end

  logic [NUM_TAGS-1:0] drop;
  logic [NUM_TAGS-1:0] free_vec;
  assign drop     = SINGLE_MODE ? '1 : ovl;
  assign free_vec = ~vld_q | drop;

  // Slot for the new method: first free, otherwise least recently used
  logic             vic_found;
  logic [IDX_W-1:0] victim;
  always_comb begin
    vic_found = 1'b0;
    victim    = '0;
    for (int i = 0; i < NUM_TAGS; i++) begin
      if (!vic_found && free_vec[i]) begin
        vic_found = 1'b1;
        victim    = IDX_W'(i);
      end
    end
    if (!vic_found) begin
      for (int i = 0; i < NUM_TAGS; i++) begin
        if (age_q[i] == IDX_W'(NUM_TAGS - 1)) victim = IDX_W'(i);
      end
    end
  end

  logic [IDX_W-1:0]    touch;
  logic [NUM_TAGS-1:0] vld_fill;
  assign touch = hit ? hit_idx : victim;
  always_comb begin
    vld_fill = vld_q & ~drop;
    vld_fill[victim] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q  <= '0;
      free_q <= '0;
      cur_q  <= '0;
      for (int i = 0; i < NUM_TAGS; i++) begin
        base_q[i]  <= '0;
        start_q[i] <= '0;
        cnt_q[i]   <= '0;
        age_q[i]   <= IDX_W'(i);
      end
    end else if (req_fire) begin
      for (int i = 0; i < NUM_TAGS; i++) begin
        if (age_q[i] < age_q[touch]) age_q[i] <= age_q[i] + 1'b1;
      end
      age_q[touch] <= '0;
      if (hit) begin
        cur_q <= start_q[hit_idx];
      end else begin
        vld_q           <= vld_fill;
        base_q[victim]  <= req_base;
        start_q[victim] <= alloc_start;
        cnt_q[victim]   <= need_blk;
        free_q          <= alloc_start + need_blk[BLK_W-1:0];
        cur_q           <= alloc_start;
      end
    end
  end

  assign cur_start = cur_q;

endmodule

// File: rtl/mcache_fill.sv
module mcache_fill
  import mcache_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int NUM_BLK   = 16,
  parameter int BLK_BYTES = 64,
  parameter int LEN_W     = 11,
  localparam int BLK_W    = $clog2(NUM_BLK),
  localparam int WSH      = $clog2(BLK_BYTES / 4),
  localparam int WIDX_W   = BLK_W + WSH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic [BLK_W-1:0]  start_blk,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              wr_en,
  output logic [WIDX_W-1:0] wr_idx,
  output logic [31:0]       wr_data,
  output logic              busy
);
  fill_state_e       st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [WIDX_W-1:0] idx_q;
  logic [LEN_W-1:0]  left_q;
  logic [LEN_W:0]    len_rnd;
  logic [LEN_W-1:0]  nwords;

  assign len_rnd = {1'b0, len} + (LEN_W+1)'(3);
  assign nwords  = LEN_W'(len_rnd >> 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= FILL_IDLE;
      addr_q <= '0;
      idx_q  <= '0;
      left_q <= '0;
    end else begin
      case (st_q)
        FILL_IDLE: begin
          if (start) begin
            st_q   <= FILL_RUN;
            addr_q <= {base[ADDR_W-1:2], 2'b00};
            idx_q  <= {start_blk, {WSH{1'b0}}};
            left_q <= nwords;
          end
        end
        default: begin
          if (mem_ack) begin
            addr_q <= addr_q + ADDR_W'(4);
            idx_q  <= idx_q + 1'b1;
            left_q <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) st_q <= FILL_IDLE;
          end
        end
      endcase
    end
  end

  assign busy     = (st_q == FILL_RUN);
  assign mem_rd   = busy;
  assign mem_addr = addr_q;
  assign wr_en    = busy && mem_ack;
  assign wr_idx   = idx_q;
  assign wr_data  = mem_rdata;

endmodule

// File: rtl/mcache_store.sv
module mcache_store
  import mcache_pkg::*;
#(
  parameter int NUM_BLK   = 16,
  parameter int BLK_BYTES = 64,
  localparam int WORDS    = NUM_BLK * BLK_BYTES / 4,
  localparam int WIDX_W   = $clog2(WORDS),
  localparam int BADDR_W  = WIDX_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [WIDX_W-1:0]  wr_idx,
  input  logic [31:0]        wr_data,
  input  logic               rd_en,
  input  logic [BADDR_W-1:0] rd_addr,
  output logic               rd_valid,
  output logic [7:0]         rd_data
);
  logic [31:0] ram [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= lane_byte(ram[rd_addr[BADDR_W-1:2]], rd_addr[1:0]);
    end
  end

endmodule

// File: rtl/method_cache.sv
module method_cache
  import mcache_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int NUM_BLK     = 16,
  parameter int BLK_BYTES   = 64,
  parameter int NUM_TAGS    = 4,
  parameter int MAX_BYTES   = 1024,
  parameter bit SINGLE_MODE = 1'b0,
  localparam int OFS_W      = $clog2(MAX_BYTES),
  localparam int LEN_W      = OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_base,
  input  logic [LEN_W-1:0]  req_len,
  output logic              busy,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  input  logic              bc_valid,
  output logic              bc_ready,
  input  logic [OFS_W-1:0]  bc_offset,
  output logic              bc_rvalid,
  output logic [7:0]        bc_rdata
);
  localparam int BLK_W   = $clog2(NUM_BLK);
  localparam int BLK_SH  = $clog2(BLK_BYTES);
  localparam int WIDX_W  = $clog2(NUM_BLK * BLK_BYTES / 4);
  localparam int BADDR_W = WIDX_W + 2;

  logic             req_fire;
  logic             lookup_hit;
  logic [BLK_W-1:0] alloc_start;
  logic [BLK_W-1:0] cur_start;
  logic             wr_en;
  logic [WIDX_W-1:0] wr_idx;
  logic [31:0]      wr_data;
  logic             bc_fire;
  logic [BADDR_W-1:0] rd_addr;

  assign req_ready = !busy;
  assign bc_ready  = !busy;
  assign req_fire  = req_valid && req_ready;
  assign bc_fire   = bc_valid && bc_ready;
  assign rd_addr   = {cur_start, {BLK_SH{1'b0}}} + BADDR_W'(bc_offset);

  mcache_tags #(
    .ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK), .BLK_BYTES(BLK_BYTES),
    .NUM_TAGS(NUM_TAGS), .LEN_W(LEN_W), .SINGLE_MODE(SINGLE_MODE)
  ) u_tags (
    .clk(clk), .rst_n(rst_n), .req_fire(req_fire), .req_base(req_base),
    .req_len(req_len), .hit(lookup_hit), .alloc_start(alloc_start),
    .cur_start(cur_start)
  );

  mcache_fill #(
    .ADDR_W(ADDR_W), .NUM_BLK(NUM_BLK), .BLK_BYTES(BLK_BYTES), .LEN_W(LEN_W)
  ) u_fill (
    .clk(clk), .rst_n(rst_n), .start(req_fire && !lookup_hit),
    .base(req_base), .len(req_len), .start_blk(alloc_start),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .busy(busy)
  );

  mcache_store #(
    .NUM_BLK(NUM_BLK), .BLK_BYTES(BLK_BYTES)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_en(bc_fire), .rd_addr(rd_addr),
    .rd_valid(bc_rvalid), .rd_data(bc_rdata)
  );

endmodule

// File: rtl/mcache_chk.sv
module mcache_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              lookup_hit,
  input logic              busy,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              bc_valid,
  input logic              bc_ready,
  input logic              bc_rvalid
);
  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

  // R2
  mem_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mem_ack) |=> (!mem_rd || (mem_addr == ADDR_W'($past(mem_addr) + ADDR_W'(4)))));

  // R2
  miss_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !lookup_hit) |=> busy);

  // R2
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(mem_ack));

  // R3
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && lookup_hit) |=> (!busy && !mem_rd));

  // R4
  rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bc_valid && bc_ready) |=> bc_rvalid);

endmodule

bind method_cache mcache_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .lookup_hit(lookup_hit), .busy(busy), .mem_rd(mem_rd), .mem_addr(mem_addr),
  .mem_ack(mem_ack), .bc_valid(bc_valid), .bc_ready(bc_ready),
  .bc_rvalid(bc_rvalid)
);

// File: tb/test_method_cache.sv
module test_method_cache;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [1:0]  req_valid, req_ready, busy, mem_rd, mem_ack;
  logic [1:0]  bc_valid, bc_ready, bc_rvalid;
  logic [31:0] req_base  [2];
  logic [10:0] req_len   [2];
  logic [31:0] mem_addr  [2];
  logic [31:0] mem_rdata [2];
  logic [9:0]  bc_offset [2];
  logic [7:0]  bc_rdata  [2];

  int n_cmp = 0;
  int n_err = 0;

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic logic [31:0] mword(input logic [31:0] a);
    return {mbyte(a + 3), mbyte(a + 2), mbyte(a + 1), mbyte(a)};
  endfunction

  method_cache i_method_cache (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[0]), .req_ready(req_ready[0]),
    .req_base(req_base[0]), .req_len(req_len[0]), .busy(busy[0]),
    .mem_rd(mem_rd[0]), .mem_addr(mem_addr[0]), .mem_ack(mem_ack[0]),
    .mem_rdata(mem_rdata[0]), .bc_valid(bc_valid[0]), .bc_ready(bc_ready[0]),
    .bc_offset(bc_offset[0]), .bc_rvalid(bc_rvalid[0]), .bc_rdata(bc_rdata[0])
  );

  method_cache #(.SINGLE_MODE(1'b1)) i_method_cache_one (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid[1]), .req_ready(req_ready[1]),
    .req_base(req_base[1]), .req_len(req_len[1]), .busy(busy[1]),
    .mem_rd(mem_rd[1]), .mem_addr(mem_addr[1]), .mem_ack(mem_ack[1]),
    .mem_rdata(mem_rdata[1]), .bc_valid(bc_valid[1]), .bc_ready(bc_ready[1]),
    .bc_offset(bc_offset[1]), .bc_rvalid(bc_rvalid[1]), .bc_rdata(bc_rdata[1])
  );

  // Backing memory model: acknowledges every other cycle
  for (genvar k = 0; k < 2; k++) begin : g_mem
    always @(posedge clk) begin
      if (!rst_n) begin
        mem_ack[k]   <= 1'b0;
        mem_rdata[k] <= '0;
      end else begin
        mem_ack[k]   <= mem_rd[k] && !mem_ack[k];
        mem_rdata[k] <= mword(mem_addr[k]);
      end
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
    $finish;
  endtask

  // Issue a call/return and follow it to completion
  task automatic call(input int u, input logic [31:0] base, input int len,
                      input int exp_reads, input string req);
    int  nrd = 0;
    bit  addr_ok = 1'b1;
    bit  stall_ok = 1'b1;
    @(negedge clk);
    while (!req_ready[u]) @(negedge clk);
    req_valid[u] = 1'b1;
    req_base[u]  = base;
    req_len[u]   = 11'(len);
    @(negedge clk);
    req_valid[u] = 1'b0;
    chk(req, "busy after request", busy[u], (exp_reads != 0));
    if (exp_reads == 0) chk(req, "mem_rd on hit", mem_rd[u], 0);
    while (busy[u]) begin
      if (req_ready[u] || bc_ready[u]) stall_ok = 1'b0;
      if (mem_rd[u] && mem_ack[u]) begin
        if (mem_addr[u] != base + 32'(4 * nrd)) addr_ok = 1'b0;
        nrd++;
      end
      @(negedge clk);
    end
    chk(req, "words read", nrd, exp_reads);
    chk(req, "address order", addr_ok, 1);
    if (exp_reads != 0) chk("R5", "ready low while busy", stall_ok, 1);
  endtask

  task automatic rd(input int u, input int off, input logic [31:0] base, input string req);
    @(negedge clk);
    bc_valid[u]  = 1'b1;
    bc_offset[u] = 10'(off);
    @(negedge clk);
    bc_valid[u]  = 1'b0;
    chk(req, "bc_rvalid", bc_rvalid[u], 1);
    chk(req, $sformatf("byte at offset %0d", off), bc_rdata[u], mbyte(base + 32'(off)));
  endtask

  task automatic t_reset();
    chk("R1", "busy in reset", busy[0], 0);
    chk("R1", "req_ready in reset", req_ready[0], 1);
    chk("R1", "mem_rd in reset", mem_rd[0], 0);
    chk("R1", "bc_rvalid in reset", bc_rvalid[0], 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", busy[0], 0);
    chk("R1", "bc_ready after reset", bc_ready[0], 1);
    chk("R1", "mem_rd after reset", mem_rd[0], 0);
  endtask

  task automatic t_fill_and_hit();
    call(0, 32'h1000, 100, 25, "R2");
    rd(0, 0, 32'h1000, "R4");
    rd(0, 50, 32'h1000, "R4");
    rd(0, 99, 32'h1000, "R4");
    call(0, 32'h2000, 64, 16, "R2");
    rd(0, 63, 32'h2000, "R4");
    call(0, 32'h1000, 100, 0, "R3");
    rd(0, 7, 32'h1000, "R3");
  endtask

  task automatic t_lru();
    call(0, 32'h3000, 4, 1, "R2");
    call(0, 32'h4000, 1, 1, "R2");
    rd(0, 0, 32'h4000, "R4");
    call(0, 32'h5000, 8, 2, "R8");   // replaces 0x2000, the oldest use
    call(0, 32'h1000, 100, 0, "R8"); // refreshed by an earlier hit
    call(0, 32'h2000, 64, 16, "R8"); // evicted above
    rd(0, 5, 32'h2000, "R8");
  endtask

  task automatic t_wrap_overlap();
    call(0, 32'h6000, 600, 150, "R6"); // blocks 7..15 then 0
    rd(0, 575, 32'h6000, "R6");
    rd(0, 580, 32'h6000, "R6");
    rd(0, 599, 32'h6000, "R6");
    call(0, 32'h1000, 100, 25, "R7");  // was in block 0
    rd(0, 99, 32'h1000, "R7");
    call(0, 32'h6000, 600, 0, "R7");   // untouched by the last fill
    rd(0, 599, 32'h6000, "R7");
    call(0, 32'h8000, 1024, 256, "R6");
    rd(0, 0, 32'h8000, "R6");
    rd(0, 1023, 32'h8000, "R6");
    call(0, 32'h6000, 600, 150, "R7");
  endtask

  task automatic t_single();
    call(1, 32'h1000, 100, 25, "R9");
    call(1, 32'h1000, 100, 25, "R9");
    rd(1, 99, 32'h1000, "R9");
    call(1, 32'h2000, 64, 16, "R9");
    rd(1, 10, 32'h2000, "R9");
  endtask

  initial begin
    req_valid = '0;
    bc_valid  = '0;
    for (int i = 0; i < 2; i++) begin
      req_base[i]  = '0;
      req_len[i]   = '0;
      bc_offset[i] = '0;
    end
    repeat (3) @(negedge clk);
    t_reset();
    t_fill_and_hit();
    t_lru();
    t_wrap_overlap();
    t_single();
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

endmodule